// File: doc/BRIEF.md
# Two-Dimensional DMA Line Address Generator

This block produces the address sequence for one direction of a DMA transfer whose data is laid out as a rectangular block of lines in memory. A controller presents four configuration values: the byte address of the first line, the length of each line, the number of lines and the byte distance between the starts of consecutive lines. A single-cycle start pulse then launches a frame. The block emits one descriptor per line over a valid/ready handshake. Each descriptor carries the line's start address and the line length. A downstream engine that moves the data consumes these descriptors.

While a frame runs, `busy` stays high. A single-cycle `done` pulse marks the end of every frame and is meant to drive the interrupt logic. Each frame can be made to wait for an external synchronization pulse, for example a video frame strobe. Loop mode replays the whole frame pattern without a new start pulse. The configuration is captured when the frame starts, so software may rewrite its registers while the frame is in flight.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While and after reset, `busy`, `desc_valid` and `done` are 0 until a start pulse is accepted.
- R2: A `start` pulse seen while idle with a nonzero line count begins a frame: `busy` is 1 from the next cycle and stays 1 until the cycle after the last line's handshake. `desc_valid` is never 1 while `busy` is 0.
- R3: Line n (counting from 0) is issued with `desc_addr` = start address + n × stride, modulo 2^ADDR_W, and with `desc_len` equal to the line length. Lines are issued in increasing n.
- R4: While `desc_valid` is 1 and `desc_ready` is 0, `desc_valid`, `desc_addr` and `desc_len` hold their values into the next cycle.
- R5: `done` is a one-cycle pulse in the cycle after the handshake of a frame's last line. Without loop mode, `busy` is 0 in that same cycle.
- R6: A start with a line count of 0 raises `done` in the next cycle, issues no descriptor, and leaves `busy` at 0.
- R7: A `start` pulse that arrives while `busy` is 1 has no effect: the running frame continues unchanged and no further frame follows it.
- R8: All four configuration values and the sync-disable setting are sampled in the start cycle. Changes made to them afterwards do not alter that frame's descriptors.
- R9: When sync-disable is 0, a frame (including every loop repeat) issues no descriptor until a cycle in which `sync_pulse` is 1. The first descriptor appears in the following cycle. When sync-disable is 1, the first descriptor appears in the cycle after the start pulse, or right after the previous frame's last handshake when looping.
- R10: If `loop_en` is 1 at the last line's handshake, `done` still pulses, `busy` stays 1 and the frame restarts from line 0 with the captured configuration. If `loop_en` is 0 at that handshake, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a frame |
| loop_en | input | 1 | Repeat the frame after its last line (sampled at each frame end) |
| sync_dis | input | 1 | 1 = do not wait for `sync_pulse` (captured at start) |
| sync_pulse | input | 1 | External frame synchronization pulse |
| cfg_base | input | ADDR_W | Byte address of line 0 |
| cfg_len | input | LEN_W | Line length carried in every descriptor |
| cfg_lines | input | CNT_W | Number of lines per frame |
| cfg_stride | input | ADDR_W | Byte distance between consecutive line starts |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_addr | output | ADDR_W | Start address of the current line |
| desc_len | output | LEN_W | Length of the current line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The hardest case is the boundary between two looped frames, with sync gating added on top. The last handshake has to raise `done`, keep `busy` high, rewind to line 0 and, when sync is enabled, drop `desc_valid` until a new sync pulse arrives. The stimulus reaches this point by running a two-line frame with loop mode on and consuming both lines. It then checks the descriptor and flags in the cycle right after the wrap. In a second pass it clears loop mode just before the last handshake of the repeated frame. A separate scenario changes every configuration input and re-pulses start in the middle of a stalled frame. This shows that neither action reaches the descriptors.

// File: rtl/dma2d_pkg.sv
// Package: shared types for the 2-D DMA address generator.
// Assumes: nothing beyond SystemVerilog enum support.
package dma2d_pkg;

    // Control states of the frame sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } dma2d_state_e;

endpackage

// File: rtl/dma2d_cfg_latch.sv
// Module: holds the frame configuration captured on a start.
// Assumes: capture is a single-cycle strobe from the sequencer.
module dma2d_cfg_latch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [CNT_W-1:0]  in_lines,
    input  logic [ADDR_W-1:0] in_stride,
    input  logic              in_sync_dis,
    output logic [ADDR_W-1:0] q_base,
    output logic [LEN_W-1:0]  q_len,
    output logic [CNT_W-1:0]  q_lines,
    output logic [ADDR_W-1:0] q_stride,
    output logic              q_sync_dis
);

    // Sample the configuration registers when a frame is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_base     <= '0;
            q_len      <= '0;
            q_lines    <= '0;
            q_stride   <= '0;
            q_sync_dis <= 1'b0;
        end else if (capture) begin
            q_base     <= in_base;
            q_len      <= in_len;
            q_lines    <= in_lines;
            q_stride   <= in_stride;
            q_sync_dis <= in_sync_dis;
        end
    end

endmodule

// File: rtl/dma2d_line_walker.sv
// Module: tracks the current line index and its start address.
// Assumes: load and step are never asserted together; lines >= 1 while stepping.
module dma2d_line_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  lines,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_line
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] idx;

    // Rewind to line 0 on load, advance by one stride on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            idx      <= '0;
        end else if (load) begin
            cur_addr <= base;
            idx      <= '0;
        end else if (step) begin
            cur_addr <= cur_addr + stride;
            idx      <= idx + ONE;
        end
    end

    // Flag the final line of the frame
    always_comb last_line = (idx == lines - ONE);

endmodule

// File: rtl/dma2d_ctrl_fsm.sv
// Module: frame sequencer - start acceptance, sync wait, issue, loop and done.
// Assumes: cnt_zero and sync_dis_now describe the raw inputs in the start cycle.
module dma2d_ctrl_fsm
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic sync_dis_now,
    input  logic sync_dis_q,
    input  logic loop_en,
    input  logic sync_pulse,
    input  logic desc_ready,
    input  logic last_line,
    output logic capture,
    output logic load,
    output logic step,
    output logic desc_valid,
    output logic busy,
    output logic done
);

    dma2d_state_e state, state_nx;
    logic         hs_last;

    // Decode strobes for the datapath
    always_comb begin
        desc_valid = (state == ST_ISSUE);
        busy       = (state != ST_IDLE);
        capture    = (state == ST_IDLE) && start;
        hs_last    = desc_valid && desc_ready && last_line;
        step       = desc_valid && desc_ready && !last_line;
        load       = capture || (hs_last && loop_en);
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (capture && !cnt_zero)
                    state_nx = sync_dis_now ? ST_ISSUE : ST_WAIT;
            ST_WAIT:
                if (sync_pulse) state_nx = ST_ISSUE;
            ST_ISSUE:
                if (hs_last) begin
                    if (!loop_en)        state_nx = ST_IDLE;
                    else if (sync_dis_q) state_nx = ST_ISSUE;
                    else                 state_nx = ST_WAIT;
                end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (capture && cnt_zero) || hs_last;
        end
    end

endmodule

// File: rtl/dma2d_addr_gen.sv
// Module: 2-D DMA address generator top. Emits one {address, length}
// descriptor per line of a frame, with optional sync gating and looping.
// Assumes: start is a pulse; descriptor consumer follows valid/ready rules.
module dma2d_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loop_en,
    input  logic              sync_dis,
    input  logic              sync_pulse,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_lines,
    input  logic [ADDR_W-1:0] cfg_stride,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [LEN_W-1:0]  desc_len,
    output logic              busy,
    output logic              done
);

    logic              capture, load, step, last_line, cnt_zero;
    logic [ADDR_W-1:0] q_base, q_stride, walk_base;
    logic [CNT_W-1:0]  q_lines;
    logic [LEN_W-1:0]  q_len;
    logic              q_sync_dis;

    // Line 0 address comes from the raw input at launch, else from the latch
    always_comb begin
        cnt_zero  = (cfg_lines == '0);
        walk_base = capture ? cfg_base : q_base;
        desc_len  = q_len;
    end

    dma2d_cfg_latch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .in_base    (cfg_base),
        .in_len     (cfg_len),
        .in_lines   (cfg_lines),
        .in_stride  (cfg_stride),
        .in_sync_dis(sync_dis),
        .q_base     (q_base),
        .q_len      (q_len),
        .q_lines    (q_lines),
        .q_stride   (q_stride),
        .q_sync_dis (q_sync_dis)
    );

    dma2d_line_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base     (walk_base),
        .stride   (q_stride),
        .lines    (q_lines),
        .cur_addr (desc_addr),
        .last_line(last_line)
    );

    dma2d_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cnt_zero    (cnt_zero),
        .sync_dis_now(sync_dis),
        .sync_dis_q  (q_sync_dis),
        .loop_en     (loop_en),
        .sync_pulse  (sync_pulse),
        .desc_ready  (desc_ready),
        .last_line   (last_line),
        .capture     (capture),
        .load        (load),
        .step        (step),
        .desc_valid  (desc_valid),
        .busy        (busy),
        .done        (done)
    );

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Module: protocol checker bound to the address generator top.
// Assumes: observes only the top-level ports.
module dma2d_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              sync_pulse,
    input logic [CNT_W-1:0]  cfg_lines,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [LEN_W-1:0]  desc_len,
    input logic              busy,
    input logic              done
);

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> busy); // R2

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_len)); // R4

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(desc_valid && desc_ready) || $past(start && !busy)); // R5

    AST_ZERO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && cfg_lines == '0 |=> done && !busy && !desc_valid); // R6

    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy && desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr)); // R7

    AST_SYNC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !desc_valid && !sync_pulse |=> !desc_valid); // R9

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sync_pulse(sync_pulse),
    .cfg_lines (cfg_lines),
    .desc_valid(desc_valid),
    .desc_ready(desc_ready),
    .desc_addr (desc_addr),
    .desc_len  (desc_len),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_dma2d_addr_gen.sv
// Bench: directed scenarios for the 2-D DMA address generator.
module sim_dma2d_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, loop_en = 1'b0, sync_dis = 1'b1, sync_pulse = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_stride = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [CW-1:0] cfg_lines = '0;
    logic          desc_valid, desc_ready = 1'b0, busy, done;
    logic [AW-1:0] desc_addr;
    logic [LW-1:0] desc_len;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en),
        .sync_dis(sync_dis), .sync_pulse(sync_pulse), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_lines(cfg_lines), .cfg_stride(cfg_stride),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_len(desc_len), .busy(busy), .done(done)
    );

    // Record one check; print actual and expected on mismatch
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Load configuration inputs (applied at a negative edge)
    task automatic set_cfg(input logic [AW-1:0] b, input logic [LW-1:0] l,
                           input logic [CW-1:0] n, input logic [AW-1:0] s);
        cfg_base = b; cfg_len = l; cfg_lines = n; cfg_stride = s;
    endtask

    // One-cycle start pulse; returns at the negedge after the sampling edge
    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Consume one line after `stall` cycles of backpressure, checking it
    task automatic take_line(input logic [AW-1:0] ea, input logic [LW-1:0] el,
                             input int stall, input string req);
        chk({req, " valid"}, desc_valid, 1'b1);
        chk({req, " addr"}, desc_addr, ea);
        chk({req, " len"}, desc_len, el);
        for (int k = 0; k < stall; k++) begin
            desc_ready = 1'b0;
            @(negedge clk);
            chk("R4 hold valid", desc_valid, 1'b1);
            chk("R4 hold addr", desc_addr, ea);
            chk("R4 hold len", desc_len, el);
        end
        desc_ready = 1'b1;
        @(negedge clk);
        desc_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 valid in reset", desc_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 valid after reset", desc_valid, 1'b0);
        chk("R1 done after reset", done, 1'b0);
    endtask

    // R2 R3 R5: plain four-line frame, no stalls
    task automatic t_basic();
        logic [AW-1:0] b = 32'h0000_1000, s = 32'h0000_0100;
        sync_dis = 1'b1; loop_en = 1'b0;
        set_cfg(b, 16'd64, 16'd4, s);
        pulse_start();
        chk("R2 busy after start", busy, 1'b1);
        for (int n = 0; n < 4; n++) begin
            chk("R5 no early done", done, 1'b0);
            take_line(b + AW'(n) * s, 16'd64, 0, "R3 basic");
        end
        chk("R5 done pulse", done, 1'b1);
        chk("R5 busy low at done", busy, 1'b0);
        @(negedge clk);
        chk("R5 done one cycle", done, 1'b0);
    endtask

    // R3 R4: backpressure and address wrap-around
    task automatic t_stall_wrap();
        logic [AW-1:0] b = 32'hFFFF_FF00, s = 32'h0000_0080;
        set_cfg(b, 16'd7, 16'd3, s);
        pulse_start();
        for (int n = 0; n < 3; n++)
            take_line(b + AW'(n) * s, 16'd7, n + 1, "R3 wrap");
        chk("R5 done after stalls", done, 1'b1);
    endtask

    // R6: zero line count
    task automatic t_zero();
        set_cfg(32'h2000, 16'd8, 16'd0, 32'h10);
        pulse_start();
        chk("R6 done", done, 1'b1);
        chk("R6 busy", busy, 1'b0);
        chk("R6 valid", desc_valid, 1'b0);
        @(negedge clk);
        chk("R6 no descriptor later", desc_valid, 1'b0);
        chk("R6 done one cycle", done, 1'b0);
    endtask

    // R7 R8: restart and config rewrite while busy
    task automatic t_busy_changes();
        logic [AW-1:0] b = 32'h0000_4000, s = 32'h0000_0040;
        set_cfg(b, 16'd32, 16'd3, s);
        pulse_start();
        set_cfg(32'h0009_0000, 16'd5, 16'd9, 32'h4);
        sync_dis = 1'b0;
        take_line(b, 16'd32, 1, "R8 line0");
        pulse_start();
        chk("R7 start ignored addr", desc_addr, b + s);
        take_line(b + s, 16'd32, 0, "R7 line1");
        take_line(b + 2 * s, 16'd32, 0, "R8 line2");
        chk("R8 frame ended", busy, 1'b0);
        @(negedge clk);
        chk("R7 no second frame", busy, 1'b0);
        chk("R7 no second frame valid", desc_valid, 1'b0);
        sync_dis = 1'b1;
    endtask

    // R9: wait for external sync
    task automatic t_sync();
        set_cfg(32'h0000_8000, 16'd16, 16'd2, 32'h200);
        sync_dis = 1'b0;
        pulse_start();
        sync_dis = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R9 busy while waiting", busy, 1'b1);
            chk("R9 no line before sync", desc_valid, 1'b0);
            @(negedge clk);
        end
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        take_line(32'h0000_8000, 16'd16, 0, "R9 after sync");
        take_line(32'h0000_8200, 16'd16, 0, "R9 line1");
        chk("R9 done", done, 1'b1);
    endtask

    // R10 R9: looping with and without sync gating
    task automatic t_loop(input logic use_sync);
        logic [AW-1:0] b = 32'h0001_0000, s = 32'h30;
        set_cfg(b, 16'd12, 16'd2, s);
        sync_dis = !use_sync; loop_en = 1'b1;
        pulse_start();
        if (use_sync) begin
            sync_pulse = 1'b1; @(negedge clk); sync_pulse = 1'b0;
        end
        take_line(b, 16'd12, 0, "R10 f0 l0");
        take_line(b + s, 16'd12, 0, "R10 f0 l1");
        chk("R10 done on wrap", done, 1'b1);
        chk("R10 busy on wrap", busy, 1'b1);
        if (use_sync) begin
            chk("R9 loop waits sync", desc_valid, 1'b0);
            @(negedge clk);
            chk("R9 loop still waits", desc_valid, 1'b0);
            sync_pulse = 1'b1; @(negedge clk); sync_pulse = 1'b0;
        end
        take_line(b, 16'd12, 0, "R10 f1 l0");
        loop_en = 1'b0;
        take_line(b + s, 16'd12, 0, "R10 f1 l1");
        chk("R10 final done", done, 1'b1);
        chk("R10 stops after loop cleared", busy, 1'b0);
        sync_dis = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall_wrap();
        t_zero();
        t_busy_changes();
        t_sync();
        t_loop(1'b0);
        t_loop(1'b1);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule